// File: doc/BRIEF.md
# Asymmetric Edge Delay Qualifier

This block qualifies a single logic level with separate delays for its two edges. A change at the input reaches the output only once the input has held its new level without a break for a programmed number of time-base ticks. The delay for a rising change and the delay for a falling change are two separate runtime inputs, so one edge can be filtered while the other is stretched. A long delay on the rising side rejects short glitches and bounce. A delay on the falling side extends every accepted pulse by a fixed time.

A single counter holds the number of ticks that have passed since the input first differed from the output. It clears whenever the two agree. It advances only on cycles where the tick enable is high, so a prescaler can set the time unit. A typical unit is one millisecond, and debounce settings then fall below about a hundred ticks. An optional chain of flops at the input brings an asynchronous signal into the clock domain before it is qualified.

Top module: `edge_delay_qualifier`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sig_out` becomes 0 and the tick count clears. After reset, a high input with `rise_dly` = 3 and a tick every cycle leaves `sig_out` low for three edges.
- R2: A rising change propagates on the first clock edge at which the qualified input is high and the count equals or exceeds `rise_dly`. With a tick every cycle and no break, `sig_out` rises on the (`rise_dly`+1)-th edge that sees the input high.
- R3: A falling change propagates in the same way against `fall_dly`. With a tick every cycle, `sig_out` falls on the (`fall_dly`+1)-th edge that sees the input low.
- R4: With a tick every cycle, a high input pulse that lasts `rise_dly` clock cycles or fewer never appears at `sig_out`.
- R5: When the delay for the pending edge is 0, `sig_out` takes the input level at the next clock edge, whether or not `tick_en` is high.
- R6: Any cycle in which the input equals `sig_out` clears the count, so a broken run of ticks restarts from zero.
- R7: With `rise_dly` = 0 and a tick every cycle, a high input pulse of L cycles produces an output pulse of L + `fall_dly` cycles.
- R8: The count advances only on cycles where `tick_en` is 1. A nonzero delay never completes while `tick_en` stays 0.
- R9: A new delay value applies at the next clock edge. Lowering it below the count reached so far makes the output change on that edge.
- R10: On an edge where the qualified input equals `sig_out`, `sig_out` keeps its value.
- R11: With `SYNC_STAGES` = N, the input passes through N flops before qualification. With both delays 0, the output follows the input after N+1 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time-base tick; the count advances only when it is 1 |
| sig_in | input | 1 | Logic level to qualify |
| rise_dly | input | DLY_W | Ticks the input must stay high before the output rises |
| fall_dly | input | DLY_W | Ticks the input must stay low before the output falls |
| sig_out | output | 1 | Qualified level |

## Verification
On every cycle the assertions check that the output holds while the qualified input matches it. They also check that the output only moves toward the level the input had, that a zero delay passes the change on the next edge, and that reset clears the output. The exact edge on which a nonzero delay completes can only be shown by the bench's scenarios. The same holds for the rejection of short pulses, the stretched pulse length, the restart after a break, tick gating, and the effect of a delay changed mid-count. The bench sweeps every pair of rise and fall delays from 0 to 5 against input pulses of 1 to 7 cycles.

// File: rtl/lqual_pkg.sv
package lqual_pkg;

    localparam int unsigned DLY_W_DEF = 16;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_RISE = 2'd1,
        PH_FALL = 2'd2
    } phase_e;

    typedef struct packed {
        logic flip;
        logic step;
        logic clear;
    } act_t;

    function automatic phase_e phase_of(input logic in_lvl, input logic out_lvl);
        if (in_lvl == out_lvl) begin
            return PH_HOLD;
        end
        return in_lvl ? PH_RISE : PH_FALL;
    endfunction

endpackage

// File: rtl/lqual_sync.sv
module lqual_sync #(
    parameter int unsigned STAGES = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] st;
            always_ff @(posedge clk) begin
                if (rst) begin
                    st <= '0;
                end else begin
                    st[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        st[i] <= st[i-1];
                    end
                end
            end
            assign q = st[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lqual_sel.sv
module lqual_sel
    import lqual_pkg::*;
#(
    parameter int unsigned W = DLY_W_DEF
) (
    input  phase_e         phase,
    input  logic [W-1:0]   cnt,
    input  logic           tick,
    input  logic [W-1:0]   rise_dly,
    input  logic [W-1:0]   fall_dly,
    output act_t           act
);
    logic [W-1:0] target;
    logic         reached;

    always_comb begin
        target  = (phase == PH_RISE) ? rise_dly : fall_dly;
        reached = (cnt >= target);
        act     = '0;
        case (phase)
            PH_HOLD: act.clear = 1'b1;
            default: begin
                if (reached) begin
                    act.flip  = 1'b1;
                    act.clear = 1'b1;
                end else if (tick) begin
                    act.step = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/lqual_cnt.sv
module lqual_cnt
    import lqual_pkg::*;
#(
    parameter int unsigned W = DLY_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  act_t         act,
    output logic         lvl,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            cnt <= '0;
        end else begin
            if (act.flip) begin
                lvl <= ~lvl;
            end
            if (act.clear) begin
                cnt <= '0;
            end else if (act.step) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/edge_delay_qualifier.sv
module edge_delay_qualifier
    import lqual_pkg::*;
#(
    parameter int unsigned DLY_W       = DLY_W_DEF,
    parameter int unsigned SYNC_STAGES = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             sig_in,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             sig_out
);
    logic             in_q;
    logic             lvl;
    logic [DLY_W-1:0] cnt;
    phase_e           phase;
    act_t             act;

    lqual_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sig_in),
        .q   (in_q)
    );

    assign phase = phase_of(in_q, lvl);

    lqual_sel #(.W(DLY_W)) u_sel (
        .phase    (phase),
        .cnt      (cnt),
        .tick     (tick_en),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly),
        .act      (act)
    );

    lqual_cnt #(.W(DLY_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .act (act),
        .lvl (lvl),
        .cnt (cnt)
    );

    assign sig_out = lvl;
endmodule

// File: rtl/lqual_chk.sv
module lqual_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_q,
    input logic [W-1:0] rise_dly,
    input logic [W-1:0] fall_dly,
    input logic         sig_out
);
    // R1
    a_r1_reset_low: assert property (@(posedge clk) $past(rst) |-> (sig_out == 1'b0));

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (in_q == sig_out) |=> $stable(sig_out));

    // R2
    a_r2_rise_toward_input: assert property (@(posedge clk) disable iff (rst)
        $rose(sig_out) |-> $past(in_q));

    // R3
    a_r3_fall_toward_input: assert property (@(posedge clk) disable iff (rst)
        $fell(sig_out) |-> !$past(in_q));

    // R5
    a_r5_zero_rise: assert property (@(posedge clk) disable iff (rst)
        (in_q && !sig_out && rise_dly == '0) |=> sig_out);

    // R5
    a_r5_zero_fall: assert property (@(posedge clk) disable iff (rst)
        (!in_q && sig_out && fall_dly == '0) |=> !sig_out);
endmodule

bind edge_delay_qualifier lqual_chk #(.W(DLY_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_q     (in_q),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly),
    .sig_out  (sig_out)
);

// File: tb/sim_edge_delay_qualifier.sv
`timescale 1ns/1ps
module sim_edge_delay_qualifier;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_en = 1'b1;
    logic         sig_in = 1'b0;
    logic [W-1:0] rise_dly = '0;
    logic [W-1:0] fall_dly = '0;
    logic         out0;
    logic         out1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    edge_delay_qualifier #(.DLY_W(W), .SYNC_STAGES(0)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .sig_in(sig_in),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .sig_out(out0)
    );

    edge_delay_qualifier #(.DLY_W(W), .SYNC_STAGES(2)) u1 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .sig_in(sig_in),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .sig_out(out1)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_wait();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sig_in = 1'b0;
        tick_en = 1'b1;
        edge_wait();
        edge_wait();
        rst = 1'b0;
    endtask

    initial begin
        edge_wait();
        do_reset();
        check("R1", out0, 1'b0);
        check("R1", out1, 1'b0);

        // R1: count cleared after reset, rise_dly 3 keeps output low 3 edges
        rise_dly = 4'd3; fall_dly = 4'd0;
        sig_in = 1'b1;
        for (int j = 1; j <= 4; j++) begin
            edge_wait();
            check(j <= 3 ? "R1" : "R2", out0, (j >= 4) ? 1'b1 : 1'b0);
        end

        // Sweep: R2, R3, R4, R7
        for (int r = 0; r <= 5; r++) begin
            for (int f = 0; f <= 5; f++) begin
                for (int len = 1; len <= 7; len++) begin
                    int hi_cnt;
                    do_reset();
                    rise_dly = W'(r);
                    fall_dly = W'(f);
                    sig_in = 1'b1;
                    hi_cnt = 0;
                    for (int j = 1; j <= len + f + 2; j++) begin
                        logic exp;
                        string tag;
                        edge_wait();
                        exp = (len >= r + 1) && (j >= r + 1) && (j <= len + f);
                        if (len < r + 1) tag = "R4";
                        else if (j <= len) tag = "R2";
                        else tag = "R3";
                        check(tag, out0, exp);
                        if (out0) hi_cnt++;
                        if (j == len) sig_in = 1'b0;
                    end
                    if (r == 0) check("R7", (hi_cnt == len + f), 1'b1);
                end
            end
        end

        // R8: no ticks, nonzero delay never completes
        do_reset();
        rise_dly = 4'd2; fall_dly = 4'd0;
        tick_en = 1'b0;
        sig_in = 1'b1;
        for (int j = 0; j < 10; j++) begin
            edge_wait();
            check("R8", out0, 1'b0);
        end
        tick_en = 1'b1;
        edge_wait();
        check("R8", out0, 1'b0);
        edge_wait();
        tick_en = 1'b0;
        check("R8", out0, 1'b0);
        edge_wait();
        check("R8", out0, 1'b1);

        // R5: zero delay follows without any tick
        do_reset();
        tick_en = 1'b0;
        rise_dly = 4'd0; fall_dly = 4'd0;
        sig_in = 1'b1;
        edge_wait();
        check("R5", out0, 1'b1);
        sig_in = 1'b0;
        edge_wait();
        check("R5", out0, 1'b0);

        // R9: lowering the delay mid-count
        do_reset();
        rise_dly = 4'd6; fall_dly = 4'd0;
        sig_in = 1'b1;
        edge_wait();
        edge_wait();
        check("R9", out0, 1'b0);
        rise_dly = 4'd1;
        edge_wait();
        check("R9", out0, 1'b1);

        // R6: broken runs restart the count
        do_reset();
        rise_dly = 4'd3; fall_dly = 4'd0;
        for (int k = 0; k < 2; k++) begin
            sig_in = 1'b1;
            for (int j = 0; j < 3; j++) begin
                edge_wait();
                check("R6", out0, 1'b0);
            end
            sig_in = 1'b0;
            edge_wait();
            check("R6", out0, 1'b0);
        end
        sig_in = 1'b1;
        for (int j = 1; j <= 4; j++) begin
            edge_wait();
            check("R6", out0, (j == 4) ? 1'b1 : 1'b0);
        end

        // R10: matching input holds output through many ticks
        for (int j = 0; j < 20; j++) begin
            tick_en = j[0];
            edge_wait();
            check("R10", out0, 1'b1);
        end

        // R11: two sync stages add two edges
        do_reset();
        rise_dly = 4'd0; fall_dly = 4'd0;
        sig_in = 1'b1;
        for (int j = 1; j <= 3; j++) begin
            edge_wait();
            check("R11", out1, (j == 3) ? 1'b1 : 1'b0);
        end
        sig_in = 1'b0;
        for (int j = 1; j <= 3; j++) begin
            edge_wait();
            check("R11", out1, (j == 3) ? 1'b0 : 1'b1);
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule